// File: doc/BRIEF.md
# Hierarchical Prefetch Throttle Arbiter

Each core has a prefetcher whose aggressiveness is adjusted at fixed intervals by a local controller. That controller sees only its own core's feedback. This block sits between the local controller and the prefetcher and adds a global check on interference. During an interval it counts five kinds of event for its core:

- prefetches that proved useful;
- prefetches that were issued;
- demand lines of other cores that this core's prefetches evicted and that were requested again afterwards;
- cycles in which this core's requests held DRAM banks;
- cycles in which other cores waited on banks because of this core.

When the one-cycle interval-end strobe arrives, the block compares the totals against programmable thresholds and sorts the core into one of three interference classes: none, borderline or severe. It then combines that class with the local up/hold/down request to produce the final decision.

A severe class forces the prefetcher down. A borderline class allows the local controller to lower aggressiveness but never to raise it. With no interference, the local request goes through unchanged. Each decision comes with a one-cycle valid flag, and the counters start fresh for the next interval. The suggested threshold settings are an accuracy of 0.6 (numerator 6, denominator 10), 90 pollution events, 50000 bank-busy cycles and 75000 bank-wait cycles. They are available as package constants, and the integrator drives them onto the threshold ports.

Top module: `pf_throttle_arbiter`

## Requirements
- R1: While reset is active and after it is released, final_dec reads 00 (hold), intf_class reads 00 (none) and dec_valid is 0 until the first interval end.
- R2: dec_valid is 1 in exactly the cycle after a cycle with interval_end high. final_dec and intf_class change only then and hold their values between decisions.
- R3: The five event counters sum their increments over one interval. Increments presented in the interval_end cycle count toward the next interval. Each counter saturates at 2^CNT_W-1.
- R4: Accuracy is high when useful × acc_den ≥ issued × acc_num and issued is non-zero. An interval with zero issued prefetches has low accuracy.
- R5: Pollution, bank-busy and bank-wait are each high when the count is greater than or equal to its threshold port (thr_pol, thr_bw, thr_bwno).
- R6: The class is severe (10) when bank-busy and bank-wait are both high and either accuracy is low or pollution is high. It is also severe when accuracy is low and both pollution and bank-busy are high.
- R7: When not severe, the class is borderline (01) if accuracy is low and bank-busy or pollution is high. It is also borderline if accuracy is high, bank-busy is high, and pollution or bank-wait is high.
- R8: In every other case the class is none (00).
- R9: Under a severe class, final_dec is 10 (down) whatever local_dec requests.
- R10: Under a borderline class, a local 01 (up) becomes 00 (hold), while a local 10 (down) or 00 (hold) passes unchanged.
- R11: Under class none, local_dec passes unchanged. The unused local code 11 is treated as hold in every class other than severe.
- R12: final_dec and intf_class never take the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_end | input | 1 | One-cycle strobe closing the current interval |
| local_dec | input | 2 | Local controller request, sampled with interval_end: 00 hold, 01 up, 10 down |
| useful_ev | input | 1 | One useful prefetch observed this cycle |
| issued_ev | input | 1 | One prefetch issued this cycle |
| pollute_ev | input | 1 | One inter-core pollution event this cycle |
| bank_busy_inc | input | BW_INC_W | Bank-busy cycles caused by this core, added this cycle |
| bank_wait_inc | input | BW_INC_W | Bank-wait cycles this core imposed on others, added this cycle |
| acc_num | input | ACC_W | Accuracy threshold numerator |
| acc_den | input | ACC_W | Accuracy threshold denominator |
| thr_pol | input | CNT_W | Pollution threshold |
| thr_bw | input | CNT_W | Bank-busy threshold |
| thr_bwno | input | CNT_W | Bank-wait threshold |
| final_dec | output | 2 | Final decision: 00 hold, 01 up, 10 down |
| dec_valid | output | 1 | High for one cycle when final_dec is new |
| intf_class | output | 2 | Interference class: 00 none, 01 borderline, 10 severe |

## Verification
The bench builds the block with CNT_W = 6 and BW_INC_W = 4, and drives the thresholds to 5 for pollution and 8 for each bandwidth metric, with an accuracy of 6/10. Those small values let every row of the classification table be reached within intervals of about ten cycles. The accuracy test includes the exact 60 % boundary. The narrow counter lets a seventy-event interval show saturation, because saturation flips the accuracy verdict. The 4-bit increments make it possible to load a full bandwidth count in the interval-end cycle and watch it land in the following interval.

// File: rtl/pft_pkg.sv
package pft_pkg;

   typedef enum logic [1:0] {
      DEC_HOLD = 2'b00,
      DEC_UP   = 2'b01,
      DEC_DOWN = 2'b10
   } dec_e;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'b00,
      CLS_BORDER = 2'b01,
      CLS_SEVERE = 2'b10
   } cls_e;

   // metric slots in the counter array
   localparam int M_USEFUL = 0;
   localparam int M_ISSUED = 1;
   localparam int M_POL    = 2;
   localparam int M_BW     = 3;
   localparam int M_BWNO   = 4;
   localparam int NUM_MET  = 5;

   // suggested threshold settings for integration
   localparam int SUGG_ACC_NUM  = 6;
   localparam int SUGG_ACC_DEN  = 10;
   localparam int SUGG_THR_POL  = 90;
   localparam int SUGG_THR_BW   = 50000;
   localparam int SUGG_THR_BWNO = 75000;

endpackage

// File: rtl/pft_metric_cnt.sv
module pft_metric_cnt #(
   parameter int CNT_W = 20,
   parameter int INC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] count
);

   localparam int SUM_W = CNT_W + 1;
   localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

   logic [SUM_W-1:0] inc_ext;
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] nxt;

   assign inc_ext = SUM_W'(inc);
   assign sum     = SUM_W'(count) + inc_ext;

   always_comb begin
      if (restart)
         nxt = CNT_W'(inc_ext);
      else if (sum > CNT_MAX)
         nxt = {CNT_W{1'b1}};
      else
         nxt = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end

endmodule

// File: rtl/pft_classifier.sv
module pft_classifier #(
   parameter int CNT_W = 20,
   parameter int ACC_W = 4
) (
   input  logic [CNT_W-1:0] useful,
   input  logic [CNT_W-1:0] issued,
   input  logic [CNT_W-1:0] pol,
   input  logic [CNT_W-1:0] bw,
   input  logic [CNT_W-1:0] bwno,
   input  logic [ACC_W-1:0] acc_num,
   input  logic [ACC_W-1:0] acc_den,
   input  logic [CNT_W-1:0] thr_pol,
   input  logic [CNT_W-1:0] thr_bw,
   input  logic [CNT_W-1:0] thr_bwno,
   output logic [1:0]       cls
);
   import pft_pkg::*;

   localparam int PROD_W = CNT_W + ACC_W;
   localparam int N_THR  = 3;

   logic [PROD_W-1:0] useful_scaled;
   logic [PROD_W-1:0] issued_scaled;
   logic              acc_hi;

   // cross-multiplied ratio test, no divider
   assign useful_scaled = PROD_W'(useful) * PROD_W'(acc_den);
   assign issued_scaled = PROD_W'(issued) * PROD_W'(acc_num);
   assign acc_hi        = (issued != '0) && (useful_scaled >= issued_scaled);

   logic [N_THR-1:0][CNT_W-1:0] met_arr;
   logic [N_THR-1:0][CNT_W-1:0] thr_arr;
   logic [N_THR-1:0]            hi;

   assign met_arr = {bwno, bw, pol};
   assign thr_arr = {thr_bwno, thr_bw, thr_pol};

   for (genvar g = 0; g < N_THR; g++) begin : g_cmp
      assign hi[g] = met_arr[g] >= thr_arr[g];
   end

   logic pol_hi, bw_hi, bwno_hi;
   logic severe, border;

   assign pol_hi  = hi[0];
   assign bw_hi   = hi[1];
   assign bwno_hi = hi[2];

   assign severe = (bw_hi && bwno_hi && (!acc_hi || pol_hi))
                || (!acc_hi && pol_hi && bw_hi);
   assign border = (!acc_hi && (bw_hi || pol_hi))
                || (acc_hi && bw_hi && (pol_hi || bwno_hi));

   always_comb begin
      if (severe)      cls = CLS_SEVERE;
      else if (border) cls = CLS_BORDER;
      else             cls = CLS_NONE;
   end

endmodule

// File: rtl/pft_combine.sv
module pft_combine (
   input  logic [1:0] cls,
   input  logic [1:0] local_dec,
   output logic [1:0] dec
);
   import pft_pkg::*;

   logic [1:0] local_clean;

   // unused code 11 is read as hold
   assign local_clean = (local_dec == 2'b11) ? DEC_HOLD : local_dec;

   always_comb begin
      unique case (cls)
         CLS_SEVERE: dec = DEC_DOWN;
         CLS_BORDER: dec = (local_clean == DEC_UP) ? DEC_HOLD : local_clean;
         default:    dec = local_clean;
      endcase
   end

endmodule

// File: rtl/pf_throttle_arbiter.sv
module pf_throttle_arbiter #(
   parameter int CNT_W    = 20,
   parameter int ACC_W    = 4,
   parameter int BW_INC_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                interval_end,
   input  logic [1:0]          local_dec,
   input  logic                useful_ev,
   input  logic                issued_ev,
   input  logic                pollute_ev,
   input  logic [BW_INC_W-1:0] bank_busy_inc,
   input  logic [BW_INC_W-1:0] bank_wait_inc,
   input  logic [ACC_W-1:0]    acc_num,
   input  logic [ACC_W-1:0]    acc_den,
   input  logic [CNT_W-1:0]    thr_pol,
   input  logic [CNT_W-1:0]    thr_bw,
   input  logic [CNT_W-1:0]    thr_bwno,
   output logic [1:0]          final_dec,
   output logic                dec_valid,
   output logic [1:0]          intf_class
);
   import pft_pkg::*;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("pf_throttle_arbiter: CNT_W must be at least 2");
   end
   if (ACC_W < 2) begin : g_bad_acc
      $error("pf_throttle_arbiter: ACC_W must be at least 2");
   end
   if (BW_INC_W > CNT_W) begin : g_bad_inc
      $error("pf_throttle_arbiter: BW_INC_W must not exceed CNT_W");
   end

   logic [NUM_MET-1:0][BW_INC_W-1:0] inc_vec;
   logic [NUM_MET-1:0][CNT_W-1:0]    cnt_vec;

   assign inc_vec[M_USEFUL] = BW_INC_W'(useful_ev);
   assign inc_vec[M_ISSUED] = BW_INC_W'(issued_ev);
   assign inc_vec[M_POL]    = BW_INC_W'(pollute_ev);
   assign inc_vec[M_BW]     = bank_busy_inc;
   assign inc_vec[M_BWNO]   = bank_wait_inc;

   for (genvar g = 0; g < NUM_MET; g++) begin : g_met
      pft_metric_cnt #(
         .CNT_W (CNT_W),
         .INC_W (BW_INC_W)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (interval_end),
         .inc     (inc_vec[g]),
         .count   (cnt_vec[g])
      );
   end

   logic [1:0] cls_now;
   logic [1:0] dec_now;

   pft_classifier #(
      .CNT_W (CNT_W),
      .ACC_W (ACC_W)
   ) u_cls (
      .useful   (cnt_vec[M_USEFUL]),
      .issued   (cnt_vec[M_ISSUED]),
      .pol      (cnt_vec[M_POL]),
      .bw       (cnt_vec[M_BW]),
      .bwno     (cnt_vec[M_BWNO]),
      .acc_num  (acc_num),
      .acc_den  (acc_den),
      .thr_pol  (thr_pol),
      .thr_bw   (thr_bw),
      .thr_bwno (thr_bwno),
      .cls      (cls_now)
   );

   pft_combine u_comb (
      .cls       (cls_now),
      .local_dec (local_dec),
      .dec       (dec_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         final_dec  <= DEC_HOLD;
         intf_class <= CLS_NONE;
         dec_valid  <= 1'b0;
      end else begin
         dec_valid <= interval_end;
         if (interval_end) begin
            final_dec  <= dec_now;
            intf_class <= cls_now;
         end
      end
   end

endmodule

// File: rtl/pft_arb_chk.sv
module pft_arb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       interval_end,
   input logic [1:0] local_dec,
   input logic [1:0] final_dec,
   input logic       dec_valid,
   input logic [1:0] intf_class
);

   // R2
   valid_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      interval_end |=> dec_valid);

   // R2
   valid_only_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !interval_end |=> !dec_valid);

   // R2
   dec_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> ($stable(final_dec) && $stable(intf_class)));

   // R9
   severe_forces_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && intf_class == 2'b10) |-> final_dec == 2'b10);

   // R10
   border_no_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && intf_class == 2'b01) |-> final_dec != 2'b01);

   // R11
   none_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && intf_class == 2'b00 && $past(local_dec) != 2'b11)
         |-> final_dec == $past(local_dec));

   // R12
   legal_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (final_dec != 2'b11) && (intf_class != 2'b11));

endmodule

bind pf_throttle_arbiter pft_arb_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .interval_end (interval_end),
   .local_dec    (local_dec),
   .final_dec    (final_dec),
   .dec_valid    (dec_valid),
   .intf_class   (intf_class)
);

// File: tb/pf_throttle_arbiter_tb.sv
module pf_throttle_arbiter_tb;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 6;
   localparam int ACC_W      = 4;
   localparam int BW_INC_W   = 4;
   localparam int N_VEC      = 16;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                interval_end;
   logic [1:0]          local_dec;
   logic                useful_ev, issued_ev, pollute_ev;
   logic [BW_INC_W-1:0] bank_busy_inc, bank_wait_inc;
   logic [ACC_W-1:0]    acc_num, acc_den;
   logic [CNT_W-1:0]    thr_pol, thr_bw, thr_bwno;
   logic [1:0]          final_dec;
   logic                dec_valid;
   logic [1:0]          intf_class;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pf_throttle_arbiter #(
      .CNT_W    (CNT_W),
      .ACC_W    (ACC_W),
      .BW_INC_W (BW_INC_W)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .interval_end  (interval_end),
      .local_dec     (local_dec),
      .useful_ev     (useful_ev),
      .issued_ev     (issued_ev),
      .pollute_ev    (pollute_ev),
      .bank_busy_inc (bank_busy_inc),
      .bank_wait_inc (bank_wait_inc),
      .acc_num       (acc_num),
      .acc_den       (acc_den),
      .thr_pol       (thr_pol),
      .thr_bw        (thr_bw),
      .thr_bwno      (thr_bwno),
      .final_dec     (final_dec),
      .dec_valid     (dec_valid),
      .intf_class    (intf_class)
   );

   // useful, issued, pollution, busy, wait, local, expected class, expected decision
   // thresholds: accuracy 6/10, pollution 5, busy 8, wait 8
   typedef struct packed {
      logic [7:0] u;
      logic [7:0] i;
      logic [7:0] p;
      logic [7:0] b;
      logic [7:0] n;
      logic [1:0] loc;
      logic [1:0] cls;
      logic [1:0] dec;
   } vec_t;

   localparam vec_t VEC [N_VEC] = '{
      '{8'd6, 8'd10, 8'd0, 8'd0, 8'd0, 2'b01, 2'b00, 2'b01}, // accurate, quiet: up passes
      '{8'd5, 8'd10, 8'd0, 8'd0, 8'd0, 2'b01, 2'b00, 2'b01}, // inaccurate, quiet: none
      '{8'd3, 8'd10, 8'd0, 8'd8, 8'd8, 2'b01, 2'b10, 2'b10}, // inaccurate, busy+wait: severe
      '{8'd3, 8'd10, 8'd0, 8'd8, 8'd0, 2'b01, 2'b01, 2'b00}, // inaccurate, busy: border, up->hold
      '{8'd3, 8'd10, 8'd0, 8'd8, 8'd0, 2'b10, 2'b01, 2'b10}, // border, down passes
      '{8'd3, 8'd10, 8'd5, 8'd0, 8'd0, 2'b01, 2'b01, 2'b00}, // inaccurate, polluting: border
      '{8'd3, 8'd10, 8'd5, 8'd8, 8'd0, 2'b00, 2'b10, 2'b10}, // inaccurate, polluting, busy: severe
      '{8'd8, 8'd10, 8'd5, 8'd8, 8'd8, 2'b01, 2'b10, 2'b10}, // accurate, all high: severe
      '{8'd8, 8'd10, 8'd5, 8'd8, 8'd0, 2'b01, 2'b01, 2'b00}, // accurate, pol+busy: border
      '{8'd8, 8'd10, 8'd0, 8'd8, 8'd8, 2'b01, 2'b01, 2'b00}, // accurate, busy+wait: border
      '{8'd8, 8'd10, 8'd5, 8'd0, 8'd8, 2'b01, 2'b00, 2'b01}, // accurate, no busy: none
      '{8'd8, 8'd10, 8'd0, 8'd8, 8'd0, 2'b10, 2'b00, 2'b10}, // accurate, only busy: none, down passes
      '{8'd6, 8'd10, 8'd0, 8'd8, 8'd8, 2'b01, 2'b01, 2'b00}, // exactly 60 %: accurate -> border
      '{8'd0, 8'd0,  8'd0, 8'd8, 8'd8, 2'b01, 2'b10, 2'b10}, // zero issued: low accuracy -> severe
      '{8'd0, 8'd0,  8'd0, 8'd0, 8'd0, 2'b11, 2'b00, 2'b00}, // local 11 read as hold
      '{8'd8, 8'd10, 8'd0, 8'd7, 8'd8, 2'b01, 2'b00, 2'b01}  // busy one under threshold: none
   };

   task automatic check(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic idle_inputs();
      useful_ev     = 1'b0;
      issued_ev     = 1'b0;
      pollute_ev    = 1'b0;
      bank_busy_inc = '0;
      bank_wait_inc = '0;
   endtask

   // accumulate events, close the interval, sample one negedge later
   task automatic run_iv(input int u, input int i, input int p, input int b,
                         input int n, input logic [1:0] loc);
      int m;
      m = u;
      if (i > m) m = i;
      if (p > m) m = p;
      if (b > m) m = b;
      if (n > m) m = n;
      for (int k = 0; k < m; k++) begin
         @(negedge clk);
         useful_ev     = (k < u);
         issued_ev     = (k < i);
         pollute_ev    = (k < p);
         bank_busy_inc = (k < b) ? 4'd1 : 4'd0;
         bank_wait_inc = (k < n) ? 4'd1 : 4'd0;
      end
      @(negedge clk);
      idle_inputs();
      interval_end = 1'b1;
      local_dec    = loc;
      @(negedge clk);
      interval_end = 1'b0;
      local_dec    = 2'b00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n        = 1'b0;
      interval_end = 1'b0;
      local_dec    = 2'b00;
      acc_num      = 4'd6;
      acc_den      = 4'd10;
      thr_pol      = 6'd5;
      thr_bw       = 6'd8;
      thr_bwno     = 6'd8;
      idle_inputs();
      repeat (3) @(negedge clk);

      // R1 reset state, during and just after reset
      check("R1 dec in reset", int'(final_dec), 0);
      check("R1 class in reset", int'(intf_class), 0);
      check("R1 valid in reset", int'(dec_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 valid after reset", int'(dec_valid), 0);
      check("R1 dec after reset", int'(final_dec), 0);

      // classification table walk: R4 R5 R6 R7 R8 R9 R10 R11
      foreach (VEC[v]) begin
         run_iv(int'(VEC[v].u), int'(VEC[v].i), int'(VEC[v].p),
                int'(VEC[v].b), int'(VEC[v].n), VEC[v].loc);
         check($sformatf("R2 valid vec%0d", v), int'(dec_valid), 1);
         check($sformatf("R6/R7/R8 class vec%0d", v), int'(intf_class), int'(VEC[v].cls));
         check($sformatf("R9/R10/R11 dec vec%0d", v), int'(final_dec), int'(VEC[v].dec));
      end

      // R2: valid lasts one cycle, outputs hold while local request and events move
      run_iv(8, 10, 0, 0, 0, 2'b01);
      check("R2 up decision", int'(final_dec), 1);
      for (int k = 0; k < 5; k++) begin
         local_dec     = 2'b10;
         bank_busy_inc = 4'd9;
         bank_wait_inc = 4'd9;
         @(negedge clk);
         check("R2 valid low between", int'(dec_valid), 0);
         check("R2 dec held between", int'(final_dec), 1);
      end
      idle_inputs();
      local_dec = 2'b00;
      // close that loaded interval to clear it: severe expected (busy+wait high, no issues)
      @(negedge clk);
      interval_end = 1'b1;
      @(negedge clk);
      interval_end = 1'b0;
      check("R3 accumulated busy", int'(intf_class), 2);

      // R3: increments in the interval_end cycle belong to the next interval
      @(negedge clk);
      interval_end  = 1'b1;
      local_dec     = 2'b01;
      bank_busy_inc = 4'd8;
      bank_wait_inc = 4'd8;
      @(negedge clk);
      interval_end  = 1'b0;
      local_dec     = 2'b00;
      idle_inputs();
      check("R3 end-cycle events not in closing interval", int'(intf_class), 0);
      check("R3 closing interval dec", int'(final_dec), 1);
      run_iv(3, 10, 0, 0, 0, 2'b01);
      check("R3 end-cycle events in next interval", int'(intf_class), 2);
      check("R3 next interval dec", int'(final_dec), 2);

      // R3 saturation: 70 issued clamps to 63, making 40 useful count as accurate
      run_iv(40, 70, 0, 8, 8, 2'b01);
      check("R3 saturation class", int'(intf_class), 1);
      check("R3 saturation dec", int'(final_dec), 0);

      // R4 zero issued with accurate-looking useful count is still low
      run_iv(4, 0, 0, 8, 0, 2'b01);
      check("R4 zero issued low accuracy", int'(intf_class), 1);

      // R12 legal codes after a severe decision with local 11
      run_iv(0, 10, 0, 8, 8, 2'b11);
      check("R12 severe with local 11", int'(final_dec), 2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule